// File: doc/BRIEF.md
# Gshare Branch Direction Predictor with Taken-Biased Boot Fill

This block predicts the direction of conditional branches in a fetch word that holds several instruction positions, called slices. A table of saturating counters is indexed by a hash of the fetch-word address and a global history register. Each table entry carries one counter per slice. The top bit of each counter gives that slice's prediction.

Reset leaves the counter storage unknown. The block does not clear it to zero. Instead, a sequencer walks an address counter over every entry and writes the all-ones value, which is the strongly-taken state. A cold predictor therefore calls loop branches taken from the start, without waiting for history to build up. While the walk runs, `ready` stays low, every prediction reads as taken and updates are discarded.

The fetch stage applies a word address and reads the per-slice bits in the same cycle. The resolve stage returns the word address, the history value that was current when the word was predicted, a mask of the slices that held conditional branches, and their outcomes. The global history is driven out so that fetch can take that snapshot.

Top module: `gshare_predictor`

## Requirements
- R1: After reset is released, `ready` is low for exactly DEPTH = 2^IDX_W rising clock edges. It goes high after the edge that writes the last entry and then stays high.
- R2: While `ready` is low, `pred_taken` is all ones, and an update has no effect on any counter or on `ghr_o`.
- R3: Once the boot fill completes, every counter holds all ones, so any address predicts taken in every slice until that entry is updated.
- R4: The table index is F(address) XOR F(history). F(v) XORs bit b of v into index bit (b mod IDX_W). The prediction uses `pred_addr` and `ghr_o`. An update uses `upd_addr` and `upd_hist`.
- R5: `pred_taken[s]` equals the most significant bit of the counter for slice s in the indexed entry. The counter occupies bits [s*CTR_W +: CTR_W] of the entry.
- R6: When `ready` and `upd_valid` are high, each slice s with `upd_mask[s]`=1 increments its counter if `upd_taken[s]`=1 and decrements it otherwise. Counting saturates at all ones and at zero. Slices with a mask bit of 0 keep their value.
- R7: `ghr_o` resets to zero. On each accepted update with at least one mask bit set, it shifts left by one and bit 0 takes the OR of `upd_mask & upd_taken`. Otherwise it holds.
- R8: A prediction and an update that address the same entry in the same cycle give the counter value from before the write (read before write). The written value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | WA_W | Fetch-word address to predict |
| pred_taken | output | SLICES | Per-slice direction, 1 = taken |
| upd_valid | input | 1 | Update request |
| upd_addr | input | WA_W | Fetch-word address of resolved word |
| upd_hist | input | HIST_W | History snapshot taken at prediction time |
| upd_mask | input | SLICES | Slices holding a resolved conditional branch |
| upd_taken | input | SLICES | Actual outcome per slice |
| ghr_o | output | HIST_W | Current global history |
| ready | output | 1 | Boot fill complete |

## Verification
Directed runs cover the boot fill. During the fill, updates are presented that would turn an entry to not-taken if they were not dropped, and a later single decrement shows whether any of them landed. A run of repeated taken outcomes followed by not-taken outcomes on one entry separates saturating counters from wrapping ones: a counter that wraps would flip to taken when pushed below zero. Random traffic confined to a few addresses, with history snapshots that are either current or arbitrary, compares every prediction and the history against a model in the bench. This exercises the index hash, slice masking and same-entry read-before-write collisions.

// File: rtl/gsh_pkg.sv
package gsh_pkg;
  typedef enum logic {
    BOOT_FILL = 1'b0,
    BOOT_DONE = 1'b1
  } boot_st_e;
endpackage

// File: rtl/gsh_index.sv
module gsh_index #(
  parameter int WA_W   = 30,
  parameter int HIST_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic [WA_W-1:0]   addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] addr_fold;
  logic [IDX_W-1:0] hist_fold;

  always_comb begin
    addr_fold = '0;
    for (int b = 0; b < WA_W; b++) addr_fold[b % IDX_W] ^= addr[b];
  end

  always_comb begin
    hist_fold = '0;
    for (int b = 0; b < HIST_W; b++) hist_fold[b % IDX_W] ^= hist[b];
  end

  assign idx = addr_fold ^ hist_fold;
endmodule

// File: rtl/gsh_ctr_upd.sv
module gsh_ctr_upd #(
  parameter int SLICES = 2,
  parameter int CTR_W  = 2
) (
  input  logic                    en,
  input  logic [SLICES*CTR_W-1:0] old_ent,
  input  logic [SLICES-1:0]       mask,
  input  logic [SLICES-1:0]       taken,
  output logic [SLICES*CTR_W-1:0] new_ent
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] nxt;
    assign cur = old_ent[s*CTR_W +: CTR_W];

    always_comb begin
      nxt = cur;
      if (mask[s]) begin
        if (taken[s]) begin
          if (cur != CMAX) nxt = cur + 1'b1;
        end else begin
          if (cur != '0) nxt = cur - 1'b1;
        end
      end
    end

    assign new_ent[s*CTR_W +: CTR_W] = nxt;

    always_comb begin
      if (en) begin
        // R6
        ctr_wrap_chk: assert (!((cur == CMAX) && (nxt == '0)) && !((cur == '0) && (nxt == CMAX)));
        // R6
        ctr_masked_chk: assert (mask[s] || (nxt == cur));
      end
    end
  end
endmodule

// File: rtl/gsh_boot_seq.sv
module gsh_boot_seq
  import gsh_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fill_we,
  output logic [IDX_W-1:0] fill_addr,
  output logic             ready
);
  localparam logic [IDX_W-1:0] LAST = '1;

  boot_st_e         st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (st_q == BOOT_FILL) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == LAST) st_d = BOOT_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BOOT_FILL;
      ptr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == BOOT_FILL) ptr_q <= ptr_d;
    end
  end

  assign fill_we   = (st_q == BOOT_FILL);
  assign fill_addr = ptr_q;
  assign ready     = (st_q == BOOT_DONE);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready);
  // R1
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (ready || (fill_addr == $past(fill_addr) + 1'b1)));
  // R1
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(fill_addr) == LAST));
endmodule

// File: rtl/gsh_table.sv
module gsh_table #(
  parameter int IDX_W = 6,
  parameter int ENT_W = 4
) (
  input  logic             clk,
  input  logic             ready,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [ENT_W-1:0] rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [ENT_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R2
  fill_data_chk: assert property (@(posedge clk) !ready |-> (we && (wdata == '1)));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int WA_W   = 30,
  parameter int HIST_W = 8,
  parameter int IDX_W  = 6,
  parameter int SLICES = 2,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WA_W-1:0]   pred_addr,
  output logic [SLICES-1:0] pred_taken,
  input  logic              upd_valid,
  input  logic [WA_W-1:0]   upd_addr,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic [SLICES-1:0] upd_mask,
  input  logic [SLICES-1:0] upd_taken,
  output logic [HIST_W-1:0] ghr_o,
  output logic              ready
);
  localparam int ENT_W = SLICES * CTR_W;

  logic             fill_we;
  logic [IDX_W-1:0] fill_addr;
  logic [IDX_W-1:0] pred_idx, upd_idx;
  logic [ENT_W-1:0] pred_ent, upd_old, upd_new;
  logic             upd_fire, hist_en;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_waddr;
  logic [ENT_W-1:0] tbl_wdata;
  logic [HIST_W-1:0] ghr_q, ghr_d;

  gsh_boot_seq #(.IDX_W(IDX_W)) u_boot (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_addr(fill_addr), .ready(ready)
  );

  gsh_index #(.WA_W(WA_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_pidx (
    .addr(pred_addr), .hist(ghr_q), .idx(pred_idx)
  );

  gsh_index #(.WA_W(WA_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_uidx (
    .addr(upd_addr), .hist(upd_hist), .idx(upd_idx)
  );

  gsh_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .ready(ready), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr_a(pred_idx), .rdata_a(pred_ent), .raddr_b(upd_idx), .rdata_b(upd_old)
  );

  assign upd_fire = upd_valid & ready;

  gsh_ctr_upd #(.SLICES(SLICES), .CTR_W(CTR_W)) u_upd (
    .en(upd_fire), .old_ent(upd_old), .mask(upd_mask), .taken(upd_taken), .new_ent(upd_new)
  );

  always_comb begin
    if (fill_we) begin
      tbl_we    = 1'b1;
      tbl_waddr = fill_addr;
      tbl_wdata = '1;
    end else begin
      tbl_we    = upd_fire;
      tbl_waddr = upd_idx;
      tbl_wdata = upd_new;
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_dir
    assign pred_taken[s] = ~ready | pred_ent[s*CTR_W + CTR_W - 1];
  end

  assign hist_en = upd_fire & (|upd_mask);

  always_comb begin
    ghr_d = {ghr_q[HIST_W-2:0], |(upd_mask & upd_taken)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr_q <= '0;
    else if (hist_en) ghr_q <= ghr_d;
  end

  assign ghr_o = ghr_q;

  // R7
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && ready && (upd_mask != '0)) |=> $stable(ghr_o));
  // R7
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && ready && (upd_mask != '0)) |=> (ghr_o[HIST_W-1:1] == $past(ghr_o[HIST_W-2:0])));
endmodule

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;
  localparam int WA_W = 30, HIST_W = 8, IDX_W = 6, SLICES = 2, CTR_W = 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = SLICES * CTR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WA_W-1:0] pred_addr = '0, upd_addr = '0;
  logic [SLICES-1:0] pred_taken, upd_mask = '0, upd_taken = '0;
  logic upd_valid = 1'b0, ready;
  logic [HIST_W-1:0] upd_hist = '0, ghr_o;

  int n_chk = 0, n_bad = 0;
  logic [ENT_W-1:0] mm [DEPTH];
  logic [HIST_W-1:0] ghr_m;

  always #5 clk = ~clk;

  gshare_predictor #(.WA_W(WA_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .SLICES(SLICES), .CTR_W(CTR_W))
  i_gshare_predictor (
    .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_hist(upd_hist), .upd_mask(upd_mask),
    .upd_taken(upd_taken), .ghr_o(ghr_o), .ready(ready)
  );

  function automatic logic [IDX_W-1:0] hidx(logic [WA_W-1:0] a, logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] r = '0;
    for (int b = 0; b < WA_W; b++) r[b % IDX_W] ^= a[b];
    for (int b = 0; b < HIST_W; b++) r[b % IDX_W] ^= h[b];
    return r;
  endfunction

  function automatic logic [SLICES-1:0] exp_dir(logic [WA_W-1:0] a, logic [HIST_W-1:0] h);
    logic [ENT_W-1:0] e = mm[hidx(a, h)];
    logic [SLICES-1:0] d;
    for (int s = 0; s < SLICES; s++) d[s] = e[s*CTR_W + CTR_W - 1];
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model_update();
    logic [ENT_W-1:0] e;
    logic [IDX_W-1:0] ix;
    if (!upd_valid) return;
    ix = hidx(upd_addr, upd_hist);
    e = mm[ix];
    for (int s = 0; s < SLICES; s++) begin
      if (upd_mask[s]) begin
        if (upd_taken[s] && e[s*CTR_W +: CTR_W] != {CTR_W{1'b1}}) e[s*CTR_W +: CTR_W] += 1;
        else if (!upd_taken[s] && e[s*CTR_W +: CTR_W] != '0) e[s*CTR_W +: CTR_W] -= 1;
      end
    end
    mm[ix] = e;
    if (upd_mask != '0) ghr_m = {ghr_m[HIST_W-2:0], |(upd_mask & upd_taken)};
  endtask

  // inputs already set just after a negedge; check, then apply model at posedge
  task automatic step(input string tag);
    #4;
    chk(pred_taken == exp_dir(pred_addr, ghr_m), {tag, " R4 R5 pred"}, pred_taken, exp_dir(pred_addr, ghr_m));
    chk(ghr_o == ghr_m, {tag, " R7 ghr"}, ghr_o, ghr_m);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic set_upd(input bit v, input logic [WA_W-1:0] a, input logic [HIST_W-1:0] h,
                         input logic [SLICES-1:0] m, input logic [SLICES-1:0] t);
    upd_valid = v; upd_addr = a; upd_hist = h; upd_mask = m; upd_taken = t;
  endtask

  initial begin : watchdog
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [WA_W-1:0] pool [4];
    logic [WA_W-1:0] hot;
    void'($urandom(32'h5eed_1234));
    ghr_m = '0;
    for (int i = 0; i < DEPTH; i++) mm[i] = '1;
    pool[0] = 30'h0000_0010; pool[1] = 30'h0123_4567; pool[2] = 30'h3fff_ffc0; pool[3] = 30'h0000_0abc;
    hot = 30'h0000_0005;

    repeat (3) @(negedge clk);
    #4;
    chk(ready == 1'b0, "R1 reset ready", ready, 0);
    chk(ghr_o == '0, "R7 reset ghr", ghr_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // boot fill with updates that must be dropped (R2)
    set_upd(1'b1, hot, '0, '1, '0);
    pred_addr = hot;
    cyc = 0;
    while (cyc < DEPTH + 4) begin
      #4;
      if (ready) break;
      chk(pred_taken == '1, "R2 fill pred", pred_taken, '1);
      chk(ghr_o == '0, "R2 fill ghr", ghr_o, 0);
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk(cyc == DEPTH, "R1 fill length", cyc, DEPTH);
    set_upd(1'b0, '0, '0, '0, '0);

    // R3: every entry taken after fill
    for (int i = 0; i < DEPTH; i++) begin
      pred_addr = WA_W'(i);
      #1;
      chk(pred_taken == '1, "R3 cold taken", pred_taken, '1);
    end
    @(negedge clk);

    // R2: one decrement after fill must still read taken (10)
    set_upd(1'b1, hot, '0, '1, '0);
    pred_addr = hot;
    step("R2 post-fill dec");
    set_upd(1'b0, '0, '0, '0, '0);
    chk(ghr_m == '0, "R2 model ghr", ghr_m, 0);
    #4;
    chk(pred_taken == '1, "R2 dropped updates", pred_taken, '1);
    @(negedge clk);

    // R6: saturation at zero, then climb back
    for (int k = 0; k < 5; k++) begin
      set_upd(1'b1, hot, ghr_m, 2'b01, 2'b00);
      pred_addr = hot;
      step("R6 down");
    end
    set_upd(1'b1, hot, ghr_m, 2'b01, 2'b01);
    step("R6 up1");
    set_upd(1'b1, hot, ghr_m, 2'b01, 2'b01);
    step("R6 up2");
    // R8: same-entry collision, check old value visible before edge
    pred_addr = hot;
    set_upd(1'b1, hot, ghr_m, 2'b11, 2'b00);
    step("R8 collide");
    set_upd(1'b0, '0, '0, '0, '0);
    step("R8 after");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [HIST_W-1:0] h;
      pred_addr = pool[$urandom_range(0, 3)];
      h = ($urandom_range(0, 3) == 0) ? HIST_W'($urandom) : ghr_m;
      set_upd($urandom_range(0, 1) == 1, pool[$urandom_range(0, 3)], h,
              SLICES'($urandom), SLICES'($urandom));
      step("R6 R7 random");
    end
    set_upd(1'b0, '0, '0, '0, '0);
    #4;
    chk(ready == 1'b1, "R1 ready stays", ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule